// File: doc/BRIEF.md
# Stream Block-Sequence Sync Scheduler

The scheduler sits inline in a block-based streaming datapath. Each input block carries a block sequence number (BSN), is marked with start-of-packet (sop) and end-of-packet (eop), and holds a fixed number of valid samples. The scheduler forwards these blocks without changing them. It replaces the incoming sync marker with one it generates itself, on an output period set as a number of samples.

Control has three inputs: a run flag, a start BSN and a one-cycle event strobe. Output is switched on at the first input block whose BSN is at least the start BSN while the run flag is high. The output sync period is counted in samples, so it need not be a whole number of blocks. A sync goes on the first block that holds each multiple of the period, counted from the start block. The enable state changes only at block boundaries, so every forwarded block is complete. A parameter can add one register stage on all outputs.

Top module: `bsn_sync_sched`

## Requirements
- R1: The output is switched on at an input sop only if `ctl_enable` is high and `in_bsn >= ctl_start_bsn`. The comparison is unsigned over `BSN_W` bits.
- R2: `out_enable` changes only in a cycle where the input has valid and sop both high. Between such cycles it keeps its value.
- R3: While `out_enable` is high, `out_valid`, `out_sop`, `out_eop`, `out_bsn` and `out_data` equal the input. While it is low, all five are zero.
- R4: With `PIPELINE=1`, every output equals the `PIPELINE=0` output one clock cycle later.
- R5: `out_start` is high for exactly the sop cycle of the first block forwarded after a start, and `out_sync` is high in that same cycle.
- R6: With s = (block BSN − start-block BSN)·`BLOCK_SIZE`, `out_sync` is high on an enabled sop when (s mod `PERIOD`) is 0 or greater than `PERIOD`−`BLOCK_SIZE`. It is low in all other cycles.
- R7: `out_start_interval` = `out_start` OR (first AND NOT `out_sync`). Here first is a flag set by `out_start`, cleared by `out_sync`, and low after reset.
- R8: An event strobe in a non-sop cycle, while the output is on and `ctl_enable` stays high, is a restart. At the next sop the output is switched off, or it starts again with a new `out_start` if that block already qualifies. After that it starts again at the first block that qualifies against the new start BSN.
- R9: When `ctl_enable` is lowered, the output is switched off at the next input sop. The block in progress is forwarded through its eop, so no output block is cut short.
- R10: In reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_enable | input | 1 | Run flag |
| ctl_start_bsn | input | BSN_W | BSN at which output may begin |
| ctl_enable_evt | input | 1 | Control event strobe; causes a restart while running |
| in_valid | input | 1 | Input sample valid |
| in_sop | input | 1 | Input start of block |
| in_eop | input | 1 | Input end of block |
| in_bsn | input | BSN_W | Input block sequence number |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_sop | output | 1 | Output start of block |
| out_eop | output | 1 | Output end of block |
| out_sync | output | 1 | Regenerated sync marker |
| out_bsn | output | BSN_W | Output block sequence number |
| out_data | output | DATA_W | Output sample |
| out_start | output | 1 | First-block pulse after a start |
| out_start_interval | output | 1 | High from a start until the next sync |
| out_enable | output | 1 | Output is on |

## Verification
The stream is run as back-to-back blocks and as blocks separated by idle gaps of one and two cycles. This shows that the enable state and the sample count advance per block and not per clock cycle. The sync schedule uses 45-sample periods over 2-sample blocks. It is followed through several periods, so a half-block offset has to fall correctly on alternate syncs. Further tests cover a stop, a start BSN in the future, and a restart that disables first and then resumes. A start BSN with its top bit set tells an unsigned compare apart from a signed one. A second instance with the extra register stage is compared cycle by cycle against the delayed output of the first instance.

// File: rtl/bsn_sync_sched.sv
module bsn_sync_sched #(
  parameter int BSN_W      = 16,
  parameter int DATA_W     = 8,
  parameter int BLOCK_SIZE = 2,
  parameter int PERIOD     = 45,
  parameter int PIPELINE   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_enable,
  input  logic [BSN_W-1:0]  ctl_start_bsn,
  input  logic              ctl_enable_evt,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [BSN_W-1:0]  in_bsn,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_sync,
  output logic [BSN_W-1:0]  out_bsn,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              out_start_interval,
  output logic              out_enable
);

  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] STEP = CW'(BLOCK_SIZE);
  localparam logic [CW-1:0] WRAP = CW'(PERIOD - BLOCK_SIZE);

  logic          en_r, pend_r, first_r;
  logic [CW-1:0] left_r, left_cur, left_nxt;
  logic          sop_in, qualify, start_now, en_cur, near;

  assign sop_in    = in_valid & in_sop & ~rst;
  assign qualify   = ctl_enable & (in_bsn >= ctl_start_bsn);
  assign start_now = sop_in & qualify & (~en_r | pend_r);
  assign en_cur    = sop_in ? qualify : en_r;
  assign left_cur  = start_now ? '0 : left_r;
  assign near      = left_cur < STEP;
  assign left_nxt  = near ? left_cur + WRAP : left_cur - STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r   <= 1'b0;
      pend_r <= 1'b0;
      left_r <= '0;
    end else begin
      en_r <= en_cur;
      if (sop_in)
        pend_r <= 1'b0;
      else if (ctl_enable_evt & ctl_enable & en_r)
        pend_r <= 1'b1;
      if (sop_in & en_cur)
        left_r <= left_nxt;
    end
  end

  logic              s_valid, s_sop, s_eop, s_sync, s_start;
  logic [BSN_W-1:0]  s_bsn;
  logic [DATA_W-1:0] s_data;

  assign s_valid = in_valid & en_cur;
  assign s_sop   = in_sop & s_valid;
  assign s_eop   = in_eop & s_valid;
  assign s_sync  = sop_in & en_cur & near;
  assign s_start = start_now;
  assign s_bsn   = en_cur ? in_bsn : '0;
  assign s_data  = en_cur ? in_data : '0;

  generate
    if (PIPELINE == 0) begin : g_direct
      assign out_valid  = s_valid;
      assign out_sop    = s_sop;
      assign out_eop    = s_eop;
      assign out_sync   = s_sync;
      assign out_start  = s_start;
      assign out_bsn    = s_bsn;
      assign out_data   = s_data;
      assign out_enable = en_cur;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid  <= 1'b0;
          out_sop    <= 1'b0;
          out_eop    <= 1'b0;
          out_sync   <= 1'b0;
          out_start  <= 1'b0;
          out_bsn    <= '0;
          out_data   <= '0;
          out_enable <= 1'b0;
        end else begin
          out_valid  <= s_valid;
          out_sop    <= s_sop;
          out_eop    <= s_eop;
          out_sync   <= s_sync;
          out_start  <= s_start;
          out_bsn    <= s_bsn;
          out_data   <= s_data;
          out_enable <= en_cur;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            first_r <= 1'b0;
    else if (out_start) first_r <= 1'b1;
    else if (out_sync)  first_r <= 1'b0;
  end

  assign out_start_interval = ~rst & (out_start | (first_r & ~out_sync));

  logic open_r;
  always_ff @(posedge clk) begin
    if (rst)                              open_r <= 1'b0;
    else if (out_valid & out_eop)         open_r <= 1'b0;
    else if (out_valid & out_sop)         open_r <= 1'b1;
  end

  p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    !out_enable |-> !out_valid && !out_sop && !out_eop);

  p_rise_on_sop_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_enable) |-> out_valid && out_sop);

  p_start_with_sync_r5: assert property (@(posedge clk) disable iff (rst)
    out_start |-> out_sync && out_sop && out_enable);

  p_sync_on_sop_r6: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> out_sop && out_valid);

  p_interval_start_r7: assert property (@(posedge clk) disable iff (rst)
    out_start |-> out_start_interval);

  p_interval_sync_r7: assert property (@(posedge clk) disable iff (rst)
    out_sync && !out_start |-> !out_start_interval);

  p_interval_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_start_interval && !out_sync |=> out_start_interval || out_sync);

  p_no_cut_block_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_sop |-> open_r);

  p_off_between_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(out_enable) |-> !open_r);

endmodule

// File: tb/bsn_sync_sched_test.sv
module bsn_sync_sched_test;
  localparam int BW = 16;
  localparam int DW = 8;
  localparam int B  = 2;
  localparam int P  = 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          ctl_enable = 0, ctl_enable_evt = 0;
  logic [BW-1:0] ctl_start_bsn = '0;
  logic          in_valid = 0, in_sop = 0, in_eop = 0;
  logic [BW-1:0] in_bsn = '0;
  logic [DW-1:0] in_data = '0;

  logic          o_valid, o_sop, o_eop, o_sync, o_start, o_int, o_en;
  logic [BW-1:0] o_bsn;
  logic [DW-1:0] o_data;
  logic          q_valid, q_sop, q_eop, q_sync, q_start, q_int, q_en;
  logic [BW-1:0] q_bsn;
  logic [DW-1:0] q_data;

  bsn_sync_sched #(.BSN_W(BW), .DATA_W(DW), .BLOCK_SIZE(B), .PERIOD(P), .PIPELINE(0)) uut (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_start_bsn(ctl_start_bsn),
    .ctl_enable_evt(ctl_enable_evt), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_bsn(in_bsn), .in_data(in_data), .out_valid(o_valid), .out_sop(o_sop), .out_eop(o_eop),
    .out_sync(o_sync), .out_bsn(o_bsn), .out_data(o_data), .out_start(o_start),
    .out_start_interval(o_int), .out_enable(o_en));

  bsn_sync_sched #(.BSN_W(BW), .DATA_W(DW), .BLOCK_SIZE(B), .PERIOD(P), .PIPELINE(1)) uut_p1 (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_start_bsn(ctl_start_bsn),
    .ctl_enable_evt(ctl_enable_evt), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_bsn(in_bsn), .in_data(in_data), .out_valid(q_valid), .out_sop(q_sop), .out_eop(q_eop),
    .out_sync(q_sync), .out_bsn(q_bsn), .out_data(q_data), .out_start(q_start),
    .out_start_interval(q_int), .out_enable(q_en));

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  logic          m_en = 0, m_pend = 0, m_first = 0;
  logic [BW-1:0] m_run = '0;
  logic [30:0]   prev_vec = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit sync_due(input logic [BW-1:0] bsn);
    logic [BW-1:0] d;
    int r;
    d = bsn - m_run;
    r = (int'(d) * B) % P;
    return (r == 0) || (r > P - B);
  endfunction

  task automatic cyc(input logic v, input logic s, input logic e,
                     input logic [BW-1:0] bsn, input logic [DW-1:0] dat, input logic evt);
    logic dec, st, sy, en;
    logic [30:0] vec, qvec;
    @(negedge clk);
    in_valid = v; in_sop = s; in_eop = e; in_bsn = bsn; in_data = dat;
    ctl_enable_evt = evt;
    #1;
    st = 0;
    if (v && s) begin
      dec = ctl_enable && (bsn >= ctl_start_bsn);   // R1 unsigned compare
      st = dec && (!m_en || m_pend);
      m_pend = 0;
      m_en = dec;
      if (st) m_run = bsn;
    end else if (evt && ctl_enable && m_en) begin
      m_pend = 1;                                    // R8 restart armed
    end
    en = m_en;
    sy = en && v && s && sync_due(bsn);
    chk("R2 enable", {31'd0, o_en}, {31'd0, en});
    chk("R3 valid", {31'd0, o_valid}, {31'd0, v & en});
    chk("R3 sop", {31'd0, o_sop}, {31'd0, v & s & en});
    chk("R9 eop", {31'd0, o_eop}, {31'd0, v & e & en});
    chk("R3 bsn", {16'd0, o_bsn}, {16'd0, en ? bsn : 16'd0});
    chk("R3 data", {24'd0, o_data}, {24'd0, en ? dat : 8'd0});
    chk("R5 start", {31'd0, o_start}, {31'd0, st});
    chk("R6 sync", {31'd0, o_sync}, {31'd0, sy});
    chk("R7 interval", {31'd0, o_int}, {31'd0, st | (m_first & ~sy)});
    if (st) m_first = 1; else if (sy) m_first = 0;
    vec  = {o_valid, o_sop, o_eop, o_sync, o_start, o_int, o_en, o_bsn, o_data};
    qvec = {q_valid, q_sop, q_eop, q_sync, q_start, q_int, q_en, q_bsn, q_data};
    chk("R4 pipeline", {1'b0, qvec}, {1'b0, prev_vec});
    prev_vec = vec;
  endtask

  task automatic block(input logic [BW-1:0] bsn, input int gap);
    for (int i = 0; i < B; i++)
      cyc(1'b1, i == 0, i == B - 1, bsn, DW'(bsn * 16 + i), 1'b0);
    for (int g = 0; g < gap; g++)
      cyc(1'b0, 1'b0, 1'b0, bsn, '0, 1'b0);
  endtask

  task automatic idle(input logic evt);
    cyc(1'b0, 1'b0, 1'b0, '0, '0, evt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R10 reset enable", {31'd0, o_en}, 32'd0);
    chk("R10 reset valid", {31'd0, o_valid}, 32'd0);
    chk("R10 reset interval", {31'd0, o_int}, 32'd0);
    chk("R10 reset p1", {31'd0, q_en | q_valid | q_int}, 32'd0);
    @(negedge clk); rst = 0;

    // R1: start in future, back-to-back blocks across several periods
    ctl_enable = 1; ctl_start_bsn = 16'd5;
    for (int k = 0; k < 60; k++) block(BW'(k), 0);
    // gaps of 1 and 2 cycles between blocks
    for (int k = 60; k < 110; k++) block(BW'(k), 1 + (k % 2));

    // R9: stop then resume
    @(negedge clk); ctl_enable = 0;
    for (int k = 110; k < 115; k++) block(BW'(k), 1);
    ctl_enable = 1; ctl_start_bsn = 16'd0;
    for (int k = 115; k < 170; k++) block(BW'(k), k % 3);

    // R8: restart with a future start BSN
    ctl_start_bsn = 16'd200;
    idle(1'b1);
    for (int k = 170; k < 260; k++) block(BW'(k), 0);

    // R8: restart whose new start BSN is already reached
    ctl_start_bsn = 16'd100;
    idle(1'b1);
    for (int k = 260; k < 300; k++) block(BW'(k), 1);

    // R1: start BSN with top bit set, unsigned compare
    ctl_start_bsn = 16'h8000;
    for (int k = 0; k < 8; k++) block(BW'(16'h7FFB + k), 0);
    for (int k = 8; k < 60; k++) block(BW'(16'h7FFB + k), 2);

    idle(1'b0); idle(1'b0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule